// File: doc/BRIEF.md
# Conditional Microprogram Sequencer with Writable Control Store

This block chooses the address of the next microinstruction every cycle. It looks at the decoded type of the current microinstruction, one condition bit and the main transfer bits. It also looks at a 3-bit short-transfer field that conditional instructions carry. From these it produces the micro-PC of the next cycle. The available transfers are jump, call and return. Each transfer is either immediate or delayed: a delayed transfer first runs the word at PC+1 in a delay slot. The block also supports skip. An 8-entry return stack holds the return addresses for calls.

The control store is 56 bits wide and lives inside the block. Software loads it with a two-word idiom. The first word is a delayed call to the address to be written. The second word sits in the delay slot and is an immediate return that carries the write request. The store word is then assembled from the low 24 bits of the A operand bus (upper part) and the full 32-bit M operand bus (lower part). The write port is also brought out on the block's pins, and a debug read port returns any stored word.

The microinstruction type is encoded as 0 = ALU, 1 = byte, 2 = jump, 3 = dispatch. For a dispatch, the environment supplies the dispatch result on the target input.

Top module: `usq_top`

## Requirements
- R1: While reset is held and until its synchronised release, `upc` is 0, `in_slot` is 0, `stk_depth` is 0, and both `stk_err` and `abj_illegal` are 0.
- R2: On a jump or dispatch word whose condition is true, the main bits {ret,call} select the action: 00 = jump to target, 01 = call target, 10 = return. If `ui_n` is 1 the transfer is immediate. If `ui_n` is 0 the next `upc` is PC+1 with `in_slot` = 1, and the transfer follows one cycle later.
- R3: On a jump or dispatch word whose condition is false, the short field is used instead. Code 000 falls through to PC+1, 110 returns immediately and 111 returns after a delay slot. Codes 001 to 101 are illegal on these words: they set the sticky `abj_illegal` flag whatever the condition, and when the condition is false they fall through.
- R4: On ALU and byte words, a true condition performs the short-field action and a false one falls through to PC+1. The codes are: 000 none, 001 skip, 010 immediate call, 011 delayed call, 100 immediate jump, 101 delayed jump, 110 immediate return, 111 delayed return.
- R5: A call pushes PC+2 when it is delayed and PC+1 when it is immediate. A return continues at the popped address.
- R6: A jump or dispatch word with both ret and call set is a plain jump to the target with no stack change. It is delayed when `ui_n` is 0.
- R7: Skip advances `upc` by 2.
- R8: The stack holds 8 entries. A push onto a full stack is dropped, and a pop from an empty stack yields address 0. Either event sets the sticky `stk_err`.
- R9: A word that requests a store write in a delay slot writes {A[23:0], M[31:0]} to the pending call target at the clock edge ending that cycle. `cs_we` is high in that cycle only. A write request outside a delay slot is ignored.
- R10: In a delay slot, a transfer taken by the slot word replaces the pending one. Otherwise `upc` moves to the pending target.
- R11: `dbg_data` returns the stored word at `dbg_addr`. The store is indexed by the low 8 address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ui_kind | input | 2 | Word type: 0 ALU, 1 byte, 2 jump, 3 dispatch |
| ui_cond | input | 1 | Selected condition bit |
| ui_r | input | 1 | Main return bit |
| ui_p | input | 1 | Main call bit |
| ui_n | input | 1 | Main inhibit-delay-slot bit |
| ui_abj | input | 3 | Short-transfer field |
| ui_target | input | 14 | Transfer target / dispatch result |
| ui_wr_store | input | 1 | Store-write request |
| a_bus | input | 32 | A operand bus |
| m_bus | input | 32 | M operand bus |
| dbg_addr | input | 14 | Debug read address |
| upc | output | 14 | Current micro-PC |
| in_slot | output | 1 | Current word is a delay slot |
| stk_depth | output | 4 | Return stack occupancy |
| stk_err | output | 1 | Sticky stack overflow/underflow |
| abj_illegal | output | 1 | Sticky illegal short-field flag |
| cs_we | output | 1 | Store write enable |
| cs_waddr | output | 14 | Store write address |
| cs_wdata | output | 56 | Store write data |
| dbg_data | output | 56 | Debug read data |

## Verification
Two things share one cycle in the store-write idiom: the delay-slot word writes the store and, in the same cycle, pops the return stack. The bench sets this up with a delayed call followed by an immediate return that carries the write request. It then checks three things: the write port during that cycle, the PC and stack depth after the pop, and the word read back through the debug port. A second collision is a delay-slot word whose own transfer must override the pending one. This is judged from the `upc` sequence after the delayed call/return pairs.

// File: rtl/usq_pkg.sv
package usq_pkg;
  localparam logic [1:0] K_ALU  = 2'd0;
  localparam logic [1:0] K_BYTE = 2'd1;
  localparam logic [1:0] K_JUMP = 2'd2;
  localparam logic [1:0] K_DISP = 2'd3;

  localparam int BUS_W = 32;
  localparam int HI_W  = 24;
  localparam int CS_W  = BUS_W + HI_W;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_SKIP, ACT_JUMP, ACT_CALL, ACT_RET
  } act_t;
endpackage

// File: rtl/usq_stack.sv
module usq_stack #(
  parameter int PC_W  = 14,
  parameter int DEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic                           pop,
  input  logic [PC_W-1:0]                push_val,
  output logic [PC_W-1:0]                top,
  output logic [$clog2(DEPTH+1)-1:0]     depth,
  output logic                           err
);
  localparam int SP_W = $clog2(DEPTH+1);
  localparam int IX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PC_W-1:0] ent_q [DEPTH];
  logic [SP_W-1:0] sp_q, sp_n;
  logic            err_q, err_n;
  logic            full, empty, wr_ok;

  assign full  = (sp_q == SP_W'(DEPTH));
  assign empty = (sp_q == '0);
  assign wr_ok = push && !full;
  assign top   = empty ? '0 : ent_q[IX_W'(sp_q - 1'b1)];

  always_comb begin
    sp_n  = sp_q;
    err_n = err_q;
    if (push) begin
      if (full) err_n = 1'b1;
      else      sp_n  = sp_q + 1'b1;
    end else if (pop) begin
      if (empty) err_n = 1'b1;
      else       sp_n  = sp_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      err_q <= 1'b0;
    end else begin
      sp_q  <= sp_n;
      err_q <= err_n;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_ok && (sp_q == SP_W'(g))) ent_q[g] <= push_val;
    end
  end

  assign depth = sp_q;
  assign err   = err_q;

  p_depth_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SP_W'(DEPTH));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  p_push_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> (sp_q == $past(sp_q) + 1'b1));
  p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> err_q);
endmodule

// File: rtl/usq_next.sv
module usq_next
  import usq_pkg::*;
#(
  parameter int PC_W = 14
) (
  input  logic [1:0]      kind,
  input  logic            cond,
  input  logic            r,
  input  logic            p,
  input  logic            n,
  input  logic [2:0]      abj,
  input  logic [PC_W-1:0] target,
  input  logic [PC_W-1:0] pc,
  input  logic            slot,
  input  logic [PC_W-1:0] pend,
  input  logic [PC_W-1:0] pop_addr,
  output logic [PC_W-1:0] pc_n,
  output logic            slot_n,
  output logic [PC_W-1:0] pend_n,
  output logic            push,
  output logic [PC_W-1:0] push_val,
  output logic            pop,
  output logic            illegal
);
  act_t            act;
  logic            xnext;
  logic            is_ctl;
  logic            abj_ok;
  logic [PC_W-1:0] dest;
  logic [PC_W-1:0] pc_p1, pc_p2;

  assign is_ctl = (kind == K_JUMP) || (kind == K_DISP);
  assign abj_ok = (abj == 3'b000) || (abj == 3'b110) || (abj == 3'b111);
  assign illegal = is_ctl && !abj_ok;
  assign pc_p1 = pc + PC_W'(1);
  assign pc_p2 = pc + PC_W'(2);

  always_comb begin
    act   = ACT_NONE;
    xnext = 1'b0;
    if (is_ctl && cond) begin
      xnext = !n;
      unique case ({r, p})
        2'b01:   act = ACT_CALL;
        2'b10:   act = ACT_RET;
        default: act = ACT_JUMP;
      endcase
    end else if (cond || (is_ctl && abj_ok)) begin
      unique case (abj)
        3'd1:    act = ACT_SKIP;
        3'd2:    act = ACT_CALL;
        3'd3:    begin act = ACT_CALL; xnext = 1'b1; end
        3'd4:    act = ACT_JUMP;
        3'd5:    begin act = ACT_JUMP; xnext = 1'b1; end
        3'd6:    act = ACT_RET;
        3'd7:    begin act = ACT_RET;  xnext = 1'b1; end
        default: act = ACT_NONE;
      endcase
      if (is_ctl && !abj_ok) act = ACT_NONE;
    end
  end

  assign dest     = (act == ACT_RET) ? pop_addr : target;
  assign push     = (act == ACT_CALL);
  assign pop      = (act == ACT_RET);
  assign push_val = xnext ? pc_p2 : pc_p1;

  always_comb begin
    pc_n   = pc_p1;
    slot_n = 1'b0;
    pend_n = pend;
    unique case (act)
      ACT_NONE: pc_n = slot ? pend : pc_p1;
      ACT_SKIP: pc_n = slot ? pend : pc_p2;
      default: begin
        if (xnext) begin
          pc_n   = pc_p1;
          pend_n = dest;
          slot_n = 1'b1;
        end else begin
          pc_n = dest;
        end
      end
    endcase
  end
endmodule

// File: rtl/usq_store.sv
module usq_store #(
  parameter int PC_W = 14,
  parameter int AW   = 8,
  parameter int DW   = 56
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [PC_W-1:0] waddr,
  input  logic [DW-1:0]   wdata,
  input  logic [PC_W-1:0] raddr,
  output logic [DW-1:0]   rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr[AW-1:0]] <= wdata;
  end

  assign rdata = mem_q[raddr[AW-1:0]];

  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(waddr[AW-1:0])] == $past(wdata)));
endmodule

// File: rtl/usq_top.sv
module usq_top
  import usq_pkg::*;
#(
  parameter int PC_W      = 14,
  parameter int STK_DEPTH = 8,
  parameter int STORE_AW  = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [1:0]                       ui_kind,
  input  logic                             ui_cond,
  input  logic                             ui_r,
  input  logic                             ui_p,
  input  logic                             ui_n,
  input  logic [2:0]                       ui_abj,
  input  logic [PC_W-1:0]                  ui_target,
  input  logic                             ui_wr_store,
  input  logic [31:0]                      a_bus,
  input  logic [31:0]                      m_bus,
  input  logic [PC_W-1:0]                  dbg_addr,
  output logic [PC_W-1:0]                  upc,
  output logic                             in_slot,
  output logic [$clog2(STK_DEPTH+1)-1:0]   stk_depth,
  output logic                             stk_err,
  output logic                             abj_illegal,
  output logic                             cs_we,
  output logic [PC_W-1:0]                  cs_waddr,
  output logic [55:0]                      cs_wdata,
  output logic [55:0]                      dbg_data
);
  logic [1:0]      rsync_q;
  logic            rst_i_n;
  logic [PC_W-1:0] pc_q, pc_n;
  logic            slot_q, slot_n;
  logic [PC_W-1:0] pend_q, pend_n;
  logic            ill_q, ill_n;
  logic            push, pop, illegal;
  logic [PC_W-1:0] push_val, top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  usq_next #(.PC_W(PC_W)) u_next (
    .kind(ui_kind), .cond(ui_cond), .r(ui_r), .p(ui_p), .n(ui_n),
    .abj(ui_abj), .target(ui_target), .pc(pc_q), .slot(slot_q),
    .pend(pend_q), .pop_addr(top), .pc_n(pc_n), .slot_n(slot_n),
    .pend_n(pend_n), .push(push), .push_val(push_val), .pop(pop),
    .illegal(illegal)
  );

  usq_stack #(.PC_W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_i_n), .push(push), .pop(pop),
    .push_val(push_val), .top(top), .depth(stk_depth), .err(stk_err)
  );

  assign ill_n = ill_q | illegal;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pc_q   <= '0;
      slot_q <= 1'b0;
      pend_q <= '0;
      ill_q  <= 1'b0;
    end else begin
      pc_q   <= pc_n;
      slot_q <= slot_n;
      pend_q <= pend_n;
      ill_q  <= ill_n;
    end
  end

  assign cs_we    = ui_wr_store && slot_q;
  assign cs_waddr = pend_q;
  assign cs_wdata = {a_bus[HI_W-1:0], m_bus};

  usq_store #(.PC_W(PC_W), .AW(STORE_AW), .DW(CS_W)) u_store (
    .clk(clk), .rst_n(rst_i_n), .we(cs_we), .waddr(cs_waddr),
    .wdata(cs_wdata), .raddr(dbg_addr), .rdata(dbg_data)
  );

  assign upc         = pc_q;
  assign in_slot     = slot_q;
  assign abj_illegal = ill_q;

  p_illegal_sticky_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    ill_q |=> ill_q);
  p_slot_resolves_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (slot_q && !push && !pop && !slot_n && ui_kind == K_ALU && !ui_cond)
      |=> (pc_q == $past(pend_q)));
  p_xnext_step_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    slot_n |=> (pc_q == $past(pc_q) + PC_W'(1)));
  p_skip_two_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!slot_q && ui_kind == K_ALU && ui_cond && ui_abj == 3'd1)
      |=> (pc_q == $past(pc_q) + PC_W'(2)));
endmodule

// File: tb/sim_usq_top.sv
`timescale 1ns/1ps
module sim_usq_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  ui_kind;
  logic        ui_cond, ui_r, ui_p, ui_n, ui_wr_store;
  logic [2:0]  ui_abj;
  logic [13:0] ui_target, dbg_addr;
  logic [31:0] a_bus, m_bus;
  logic [13:0] upc, cs_waddr;
  logic        in_slot, stk_err, abj_illegal, cs_we;
  logic [3:0]  stk_depth;
  logic [55:0] cs_wdata, dbg_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  usq_top u0 (
    .clk(clk), .rst_n(rst_n), .ui_kind(ui_kind), .ui_cond(ui_cond),
    .ui_r(ui_r), .ui_p(ui_p), .ui_n(ui_n), .ui_abj(ui_abj),
    .ui_target(ui_target), .ui_wr_store(ui_wr_store), .a_bus(a_bus),
    .m_bus(m_bus), .dbg_addr(dbg_addr), .upc(upc), .in_slot(in_slot),
    .stk_depth(stk_depth), .stk_err(stk_err), .abj_illegal(abj_illegal),
    .cs_we(cs_we), .cs_waddr(cs_waddr), .cs_wdata(cs_wdata),
    .dbg_data(dbg_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drv(input logic [1:0] k, input logic c, input logic r, input logic p,
                     input logic n, input logic [2:0] a, input logic [13:0] t,
                     input logic w);
    ui_kind = k; ui_cond = c; ui_r = r; ui_p = p; ui_n = n;
    ui_abj = a; ui_target = t; ui_wr_store = w;
  endtask

  task automatic idle;
    drv(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 14'd0, 1'b0);
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    idle();
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    idle();
    step(); step();
    chk("R1 upc", upc, 0);
    chk("R1 slot", in_slot, 0);
    chk("R1 depth", stk_depth, 0);
    chk("R1 errs", {stk_err, abj_illegal}, 0);
    rst_n = 1'b1;
    step();
    chk("R1 upc held until sync release", upc, 0);
    step(); step();
  endtask

  task automatic t_main_jump;
    logic [13:0] p;
    p = upc;
    drv(2'd2, 1, 0, 0, 1, 3'd0, 14'd100, 0); step();
    chk("R2 immediate jump", upc, 100);
    drv(2'd3, 1, 0, 0, 1, 3'd0, 14'd150, 0); step();
    chk("R2 immediate dispatch", upc, 150);
    drv(2'd2, 1, 0, 0, 0, 3'd0, 14'd200, 0); step();
    chk("R2 delayed jump slot pc", upc, 151);
    chk("R2 slot flag", in_slot, 1);
    idle(); step();
    chk("R10 pending target taken", upc, 200);
    chk("R10 slot cleared", in_slot, 0);
    p = upc;
    drv(2'd2, 1, 1, 1, 1, 3'd0, 14'd320, 0); step();
    chk("R6 both bits immediate", upc, 320);
    chk("R6 no stack change", stk_depth, 0);
    drv(2'd2, 1, 1, 1, 0, 3'd0, 14'd340, 0); step();
    chk("R6 both bits delayed slot", upc, 321);
    idle(); step();
    chk("R6 both bits delayed target", upc, 340);
    chk("R6 depth still 0", stk_depth, 0);
    p = upc;
    drv(2'd2, 1, 0, 1, 0, 3'd0, 14'd400, 0); step();
    chk("R5 delayed call slot", upc, p + 1);
    chk("R5 delayed call push", stk_depth, 1);
    idle(); step();
    chk("R5 delayed call target", upc, 400);
    drv(2'd2, 1, 1, 0, 1, 3'd0, 14'd0, 0); step();
    chk("R5 return to pc+2", upc, p + 2);
    chk("R5 depth back", stk_depth, 0);
  endtask

  task automatic t_jump_false;
    logic [13:0] p;
    p = upc;
    drv(2'd2, 0, 0, 0, 1, 3'd0, 14'd900, 0); step();
    chk("R3 code000 false falls through", upc, p + 1);
    p = upc;
    drv(2'd2, 1, 0, 1, 1, 3'd0, 14'd300, 0); step();
    chk("R5 immediate call target", upc, 300);
    chk("R5 depth", stk_depth, 1);
    drv(2'd2, 0, 0, 0, 1, 3'd6, 14'd900, 0); step();
    chk("R3 code110 immediate return", upc, p + 1);
    chk("R3 code110 pop", stk_depth, 0);
    p = upc;
    drv(2'd2, 1, 0, 1, 1, 3'd0, 14'd300, 0); step();
    drv(2'd3, 0, 0, 0, 1, 3'd7, 14'd900, 0); step();
    chk("R3 code111 slot", upc, 301);
    chk("R3 code111 slot flag", in_slot, 1);
    idle(); step();
    chk("R3 code111 return after slot", upc, p + 1);
    chk("R3 no illegal on legal codes", abj_illegal, 0);
  endtask

  task automatic t_illegal;
    for (int c = 1; c <= 5; c++) begin
      logic [13:0] p;
      do_reset();
      chk("R3 illegal clear after reset", abj_illegal, 0);
      p = upc;
      drv(2'd2, 0, 0, 0, 1, 3'(c), 14'd900, 0); step();
      chk("R3 illegal code flagged", abj_illegal, 1);
      chk("R3 illegal code falls through", upc, p + 1);
      chk("R3 illegal code no stack", stk_depth, 0);
      idle(); step();
      chk("R3 illegal flag sticky", abj_illegal, 1);
    end
    do_reset();
  endtask

  task automatic t_alu;
    logic [13:0] p;
    for (int c = 0; c < 8; c++) begin
      p = upc;
      drv(2'(c % 2), 0, 0, 0, 0, 3'(c), 14'd700, 0); step();
      chk("R4 false cond falls through", upc, p + 1);
      chk("R4 false cond no stack", stk_depth, 0);
    end
    p = upc;
    drv(2'd0, 1, 0, 0, 0, 3'd0, 14'd700, 0); step();
    chk("R4 code000 true", upc, p + 1);
    p = upc;
    drv(2'd1, 1, 0, 0, 0, 3'd1, 14'd700, 0); step();
    chk("R7 skip by two", upc, p + 2);
    p = upc;
    drv(2'd0, 1, 0, 0, 0, 3'd2, 14'd700, 0); step();
    chk("R4 code010 immediate call", upc, 700);
    chk("R5 pushed", stk_depth, 1);
    drv(2'd0, 1, 0, 0, 0, 3'd6, 14'd0, 0); step();
    chk("R5 code110 return pc+1", upc, p + 1);
    p = upc;
    drv(2'd1, 1, 0, 0, 0, 3'd3, 14'd720, 0); step();
    chk("R4 code011 slot", upc, p + 1);
    idle(); step();
    chk("R4 code011 target", upc, 720);
    drv(2'd0, 1, 0, 0, 0, 3'd7, 14'd0, 0); step();
    chk("R4 code111 slot", upc, 721);
    idle(); step();
    chk("R5 delayed return to pc+2", upc, p + 2);
    drv(2'd0, 1, 0, 0, 0, 3'd4, 14'd740, 0); step();
    chk("R4 code100 jump", upc, 740);
    drv(2'd0, 1, 0, 0, 0, 3'd5, 14'd760, 0); step();
    chk("R4 code101 slot", upc, 741);
    drv(2'd0, 1, 0, 0, 0, 3'd1, 14'd0, 0); step();
    chk("R10 skip in slot yields pending", upc, 760);
  endtask

  task automatic t_stack;
    logic [13:0] ret [8];
    do_reset();
    for (int i = 0; i < 8; i++) begin
      ret[i] = upc + 14'd1;
      drv(2'd2, 1, 0, 1, 1, 3'd0, 14'(1000 + i * 16), 0); step();
      chk("R8 nested call target", upc, 1000 + i * 16);
    end
    chk("R8 full depth", stk_depth, 8);
    chk("R8 no error at full", stk_err, 0);
    drv(2'd2, 1, 0, 1, 1, 3'd0, 14'd2000, 0); step();
    chk("R8 overflow error", stk_err, 1);
    chk("R8 overflow dropped", stk_depth, 8);
    for (int i = 7; i >= 0; i--) begin
      drv(2'd2, 1, 1, 0, 1, 3'd0, 14'd0, 0); step();
      chk("R8 LIFO return", upc, ret[i]);
    end
    drv(2'd2, 1, 1, 0, 1, 3'd0, 14'd0, 0); step();
    chk("R8 underflow pc 0", upc, 0);
    chk("R8 underflow depth", stk_depth, 0);
    chk("R8 error sticky", stk_err, 1);
    do_reset();
  endtask

  task automatic t_write;
    logic [13:0] p;
    logic [55:0] word;
    a_bus = 32'hA5C3_1E2D; m_bus = 32'h1234_5678;
    word  = {24'hC31E2D, 32'h1234_5678};
    p = upc;
    drv(2'd0, 0, 0, 0, 0, 3'd0, 14'd0, 1); #1;
    chk("R9 write ignored outside slot", cs_we, 0);
    step();
    p = upc;
    drv(2'd2, 1, 0, 1, 0, 3'd0, 14'h0123, 0); step();
    chk("R9 call slot", upc, p + 1);
    drv(2'd2, 1, 1, 0, 1, 3'd0, 14'd0, 1); #1;
    chk("R9 write enable in slot", cs_we, 1);
    chk("R9 write address is call target", cs_waddr, 14'h0123);
    chk("R9 write data packing", cs_wdata, word);
    step();
    chk("R10 slot return overrides pending", upc, p + 2);
    chk("R9 stack balanced", stk_depth, 0);
    idle(); #1;
    chk("R9 enable drops", cs_we, 0);
    dbg_addr = 14'h0123; #1;
    chk("R11 read back", dbg_data, word);
    dbg_addr = 14'h3F23; #1;
    chk("R11 low address bits index", dbg_data, word);
    step();
  endtask

  initial begin
    rst_n = 1'b0;
    a_bus = '0; m_bus = '0; dbg_addr = '0;
    idle();
    t_reset();
    t_main_jump();
    t_jump_false();
    t_illegal();
    t_alu();
    t_stack();
    t_write();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule